// File: doc/BRIEF.md
# RAID6 Dual-Parity Syndrome Generator

This block computes both RAID6 parities for a stripe of data sources as the data streams through it. The first parity, P, is the bytewise XOR of all sources. The second parity, Q, is a weighted sum over GF(2^8), built with reduction polynomial 0x11D and generator {02}. In that sum, the bytes of the source in stripe slot i are multiplied by {02}^i. Each source is a block of `BLK_BEATS` beats, and each beat is `LANES` bytes wide. A source arrives as a contiguous run of beats on a valid/ready input. Every beat carries the source's slot number and a last flag. The block folds each beat into per-position P and Q accumulators. After the beat marked last, it plays both accumulators out on two output streams, each with its own valid.

Software starts a job with a one-cycle start pulse that carries the job settings: a mode, a disable bit for each parity, and a slot window. In the fresh mode the accumulators are cleared. In the continue mode the accumulators keep what earlier passes left, so one long stripe can be split into several jobs. In the read-modify-write mode the old P and old Q are streamed in first, and only slots inside the window are folded on top of them. Sources that are absent are simply not sent. The slot tag keeps their weights correct, and the arrival order does not matter. A request with both parities disabled is refused.

Top module: `raid6_pq_gen`

## Requirements
- R1: For each beat position b (0 to BLK_BEATS-1), p_data of drain beat b is the XOR of beat b of every source folded in during the job, on top of the starting accumulator value.
- R2: For each beat position b, q_data of drain beat b is the XOR over folded sources of gfmul({02}^idx, byte) for each byte lane. GF(2^8) uses reduction polynomial 0x11D, and idx is the in_idx tag of that source.
- R3: A source that is never sent contributes nothing. The other sources keep their own tag weights with no renumbering, and the result does not depend on the order in which sources arrive.
- R4: If job_p_off (or job_q_off) is set, that parity's valid stays low for the whole job and its accumulator is not updated. The other parity is still produced.
- R5: A start with both job_p_off and job_q_off set is refused. job_err is high for exactly the one cycle after the start, busy and in_ready stay low, and both accumulators are left unchanged.
- R6: job_mode encoding: 0 clears both accumulators at start (value 3 acts the same way). 1 keeps the accumulators from the previous job. 2 is read-modify-write, where the first BLK_BEATS input beats load old P and the next BLK_BEATS beats load old Q, with their tags ignored.
- R7: In mode 2, a source beat whose tag lies outside job_lo..job_hi (inclusive) is accepted and has no effect on either parity.
- R8: The cycle after the handshake of a beat with in_last set, drain begins. It lasts exactly BLK_BEATS cycles, emits beats 0 to BLK_BEATS-1 in order, and holds in_ready low. After drain, busy and both valids are low.
- R9: During and directly after reset, busy, in_ready, p_valid, q_valid and job_err are low.
- R10: Beat k of a source block (counted from its first beat) folds into accumulator position k mod BLK_BEATS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| job_start | input | 1 | One-cycle job request, sampled while idle |
| job_mode | input | 2 | 0 fresh, 1 continue, 2 read-modify-write |
| job_p_off | input | 1 | Suppress P for this job |
| job_q_off | input | 1 | Suppress Q for this job |
| job_lo | input | IDX_W | Lowest slot folded in mode 2 |
| job_hi | input | IDX_W | Highest slot folded in mode 2 |
| job_err | output | 1 | Pulse: request refused |
| busy | output | 1 | A job is in progress |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high with in_valid |
| in_data | input | LANES*8 | Input bytes |
| in_idx | input | IDX_W | Stripe slot of the source |
| in_last | input | 1 | Final beat of the job |
| p_valid | output | 1 | P beat valid |
| p_data | output | LANES*8 | P beat |
| q_valid | output | 1 | Q beat valid |
| q_data | output | LANES*8 | Q beat |

## Verification
The main function is tried with four kinds of stripe. Contiguous low slots check the plain weighting. Sparse masks check that absent sources keep the weights of the others. The single top slot places the largest power of {02} in the result and exercises the polynomial reduction. Descending arrival order separates slot-tag weighting from arrival-count weighting. A refused request is placed between a fresh job and a continue job, which shows whether the refusal disturbed the accumulators. Read-modify-write jobs send sources on both sides of the window, so tag filtering is distinguished from simply counting beats. A random series of jobs mixes all modes and disable bits, with a running model kept across jobs.

// File: rtl/raid6_pq_pkg.sv
package raid6_pq_pkg;

  typedef enum logic [1:0] {
    MODE_NEW  = 2'd0,
    MODE_CONT = 2'd1,
    MODE_XDST = 2'd2
  } job_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LDP   = 3'd1,
    ST_LDQ   = 3'd2,
    ST_ACC   = 3'd3,
    ST_DRAIN = 3'd4
  } pq_state_e;

  // low byte of the field polynomial x^8+x^4+x^3+x^2+1
  localparam logic [7:0] GF_RED = 8'h1D;

  function automatic logic [7:0] gf_dbl(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? GF_RED : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] sh;
    acc = 8'h00;
    sh  = a;
    for (int k = 0; k < 8; k++) begin
      if (b[k]) acc = acc ^ sh;
      sh = gf_dbl(sh);
    end
    return acc;
  endfunction

  function automatic logic [7:0] gf_exp2(input int n);
    logic [7:0] r;
    r = 8'h01;
    for (int k = 0; k < 255; k++) begin
      if (k < n) r = gf_dbl(r);
    end
    return r;
  endfunction

endpackage

// File: rtl/raid6_gf_scale.sv
module raid6_gf_scale
  import raid6_pq_pkg::*;
#(
  parameter int LANES = 8,
  parameter int IDX_W = 4
) (
  input  logic [LANES*8-1:0] din,
  input  logic [IDX_W-1:0]   idx,
  output logic [LANES*8-1:0] dout
);

  localparam int NCOEF = 1 << IDX_W;

  function automatic logic [NCOEF*8-1:0] build_tab();
    logic [NCOEF*8-1:0] t;
    for (int i = 0; i < NCOEF; i++) t[i*8 +: 8] = gf_exp2(i);
    return t;
  endfunction

  localparam logic [NCOEF*8-1:0] COEF_TAB = build_tab();

  logic [7:0] coef;
  assign coef = COEF_TAB[idx*8 +: 8];

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign dout[l*8 +: 8] = gf_mul(din[l*8 +: 8], coef);
  end

endmodule

// File: rtl/raid6_pq_acc.sv
module raid6_pq_acc #(
  parameter int WORD_W = 64,
  parameter int DEPTH  = 4,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              clr,
  input  logic              ld,
  input  logic              upd,
  input  logic [AW-1:0]     addr,
  input  logic [WORD_W-1:0] ld_data,
  input  logic [WORD_W-1:0] upd_data,
  output logic [WORD_W-1:0] rdata
);

  logic [WORD_W-1:0] mem_q [DEPTH];
  logic [WORD_W-1:0] mem_d [DEPTH];
  logic              wr_en;

  assign wr_en = clr | ld | upd;
  assign rdata = mem_q[addr];

  always_comb begin
    mem_d = mem_q;
    if (clr) begin
      for (int i = 0; i < DEPTH; i++) mem_d[i] = '0;
    end else if (ld) begin
      mem_d[addr] = ld_data;
    end else if (upd) begin
      mem_d[addr] = mem_q[addr] ^ upd_data;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem_q <= mem_d;
  end

endmodule

// File: rtl/raid6_pq_ctrl.sv
module raid6_pq_ctrl
  import raid6_pq_pkg::*;
#(
  parameter int IDX_W     = 4,
  parameter int BLK_BEATS = 4,
  localparam int AW       = (BLK_BEATS > 1) ? $clog2(BLK_BEATS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             job_start,
  input  logic [1:0]       job_mode,
  input  logic             job_p_off,
  input  logic             job_q_off,
  input  logic [IDX_W-1:0] job_lo,
  input  logic [IDX_W-1:0] job_hi,
  input  logic             in_valid,
  input  logic [IDX_W-1:0] in_idx,
  input  logic             in_last,
  output logic             in_ready,
  output logic             job_err,
  output logic             busy,
  output logic             acc_clr,
  output logic             p_ld,
  output logic             q_ld,
  output logic             p_upd,
  output logic             q_upd,
  output logic [AW-1:0]    beat,
  output logic             p_out,
  output logic             q_out
);

  pq_state_e        state_q, state_d;
  logic [AW-1:0]    beat_q, beat_d;
  logic [1:0]       mode_q, mode_d;
  logic             pon_q, pon_d;
  logic             qon_q, qon_d;
  logic [IDX_W-1:0] lo_q, lo_d;
  logic [IDX_W-1:0] hi_q, hi_d;
  logic             err_q, err_d;

  logic          hs;
  logic          req_ok;
  logic          beat_end;
  logic [AW-1:0] beat_inc;
  logic          in_range;

  assign req_ok   = ~(job_p_off & job_q_off);
  assign in_ready = (state_q == ST_LDP) | (state_q == ST_LDQ) | (state_q == ST_ACC);
  assign hs       = in_valid & in_ready;
  assign beat_end = (beat_q == AW'(BLK_BEATS - 1));
  assign beat_inc = beat_end ? '0 : AW'(beat_q + 1'b1);
  assign in_range = (mode_q != MODE_XDST) | ((in_idx >= lo_q) & (in_idx <= hi_q));

  always_comb begin
    state_d = state_q;
    beat_d  = beat_q;
    mode_d  = mode_q;
    pon_d   = pon_q;
    qon_d   = qon_q;
    lo_d    = lo_q;
    hi_d    = hi_q;
    err_d   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (job_start) begin
          if (req_ok) begin
            mode_d  = job_mode;
            pon_d   = ~job_p_off;
            qon_d   = ~job_q_off;
            lo_d    = job_lo;
            hi_d    = job_hi;
            beat_d  = '0;
            state_d = (job_mode == MODE_XDST) ? ST_LDP : ST_ACC;
          end else begin
            err_d = 1'b1;
          end
        end
      end
      ST_LDP: begin
        if (hs) begin
          beat_d = beat_inc;
          if (beat_end) state_d = ST_LDQ;
        end
      end
      ST_LDQ: begin
        if (hs) begin
          beat_d = beat_inc;
          if (beat_end) state_d = ST_ACC;
        end
      end
      ST_ACC: begin
        if (hs) begin
          if (in_last) begin
            beat_d  = '0;
            state_d = ST_DRAIN;
          end else begin
            beat_d = beat_inc;
          end
        end
      end
      ST_DRAIN: begin
        beat_d = beat_inc;
        if (beat_end) state_d = ST_IDLE;
      end
      default: begin
        state_d = ST_IDLE;
        beat_d  = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      beat_q  <= '0;
      mode_q  <= '0;
      pon_q   <= 1'b0;
      qon_q   <= 1'b0;
      lo_q    <= '0;
      hi_q    <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      beat_q  <= beat_d;
      mode_q  <= mode_d;
      pon_q   <= pon_d;
      qon_q   <= qon_d;
      lo_q    <= lo_d;
      hi_q    <= hi_d;
      err_q   <= err_d;
    end
  end

  assign job_err = err_q;
  assign busy    = (state_q != ST_IDLE);
  assign beat    = beat_q;
  assign acc_clr = (state_q == ST_IDLE) & job_start & req_ok &
                   (job_mode != MODE_CONT) & (job_mode != MODE_XDST);
  assign p_ld    = (state_q == ST_LDP) & hs;
  assign q_ld    = (state_q == ST_LDQ) & hs;
  assign p_upd   = (state_q == ST_ACC) & hs & pon_q & in_range;
  assign q_upd   = (state_q == ST_ACC) & hs & qon_q & in_range;
  assign p_out   = (state_q == ST_DRAIN) & pon_q;
  assign q_out   = (state_q == ST_DRAIN) & qon_q;

endmodule

// File: rtl/raid6_pq_gen.sv
module raid6_pq_gen
  import raid6_pq_pkg::*;
#(
  parameter int LANES     = 8,
  parameter int IDX_W     = 4,
  parameter int BLK_BEATS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 job_start,
  input  logic [1:0]           job_mode,
  input  logic                 job_p_off,
  input  logic                 job_q_off,
  input  logic [IDX_W-1:0]     job_lo,
  input  logic [IDX_W-1:0]     job_hi,
  output logic                 job_err,
  output logic                 busy,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [LANES*8-1:0]   in_data,
  input  logic [IDX_W-1:0]     in_idx,
  input  logic                 in_last,
  output logic                 p_valid,
  output logic [LANES*8-1:0]   p_data,
  output logic                 q_valid,
  output logic [LANES*8-1:0]   q_data
);

  localparam int WORD_W = LANES * 8;
  localparam int AW     = (BLK_BEATS > 1) ? $clog2(BLK_BEATS) : 1;

  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic              acc_clr, p_ld, q_ld, p_upd, q_upd, p_out, q_out;
  logic [AW-1:0]     beat;
  logic [WORD_W-1:0] q_term;
  logic [WORD_W-1:0] p_rd, q_rd;

  raid6_pq_ctrl #(.IDX_W(IDX_W), .BLK_BEATS(BLK_BEATS)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .job_start (job_start),
    .job_mode  (job_mode),
    .job_p_off (job_p_off),
    .job_q_off (job_q_off),
    .job_lo    (job_lo),
    .job_hi    (job_hi),
    .in_valid  (in_valid),
    .in_idx    (in_idx),
    .in_last   (in_last),
    .in_ready  (in_ready),
    .job_err   (job_err),
    .busy      (busy),
    .acc_clr   (acc_clr),
    .p_ld      (p_ld),
    .q_ld      (q_ld),
    .p_upd     (p_upd),
    .q_upd     (q_upd),
    .beat      (beat),
    .p_out     (p_out),
    .q_out     (q_out)
  );

  raid6_gf_scale #(.LANES(LANES), .IDX_W(IDX_W)) u_scale (
    .din  (in_data),
    .idx  (in_idx),
    .dout (q_term)
  );

  raid6_pq_acc #(.WORD_W(WORD_W), .DEPTH(BLK_BEATS)) u_acc_p (
    .clk      (clk),
    .clr      (acc_clr),
    .ld       (p_ld),
    .upd      (p_upd),
    .addr     (beat),
    .ld_data  (in_data),
    .upd_data (in_data),
    .rdata    (p_rd)
  );

  raid6_pq_acc #(.WORD_W(WORD_W), .DEPTH(BLK_BEATS)) u_acc_q (
    .clk      (clk),
    .clr      (acc_clr),
    .ld       (q_ld),
    .upd      (q_upd),
    .addr     (beat),
    .ld_data  (in_data),
    .upd_data (q_term),
    .rdata    (q_rd)
  );

  assign p_valid = p_out;
  assign q_valid = q_out;
  assign p_data  = p_out ? p_rd : '0;
  assign q_data  = q_out ? q_rd : '0;

endmodule

// File: rtl/raid6_pq_chk.sv
module raid6_pq_chk (
  input logic clk,
  input logic rst_n,
  input logic job_start,
  input logic job_p_off,
  input logic job_q_off,
  input logic job_err,
  input logic busy,
  input logic in_valid,
  input logic in_ready,
  input logic in_last,
  input logic p_valid,
  input logic q_valid
);

  // R5
  both_off_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (job_start && !busy && job_p_off && job_q_off) |=> (job_err && !busy));

  // R5
  err_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    job_err |=> !job_err);

  // R6
  start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (job_start && !busy && !(job_p_off && job_q_off)) |=> busy);

  // R8
  drain_follows_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_last) |=> ((p_valid || q_valid) && !in_ready));

  // R8
  out_no_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (p_valid || q_valid) |-> !in_ready);

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!in_ready && !p_valid && !q_valid));

endmodule

bind raid6_pq_gen raid6_pq_chk u_pq_chk (
  .clk       (clk),
  .rst_n     (rst_int_n),
  .job_start (job_start),
  .job_p_off (job_p_off),
  .job_q_off (job_q_off),
  .job_err   (job_err),
  .busy      (busy),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_last   (in_last),
  .p_valid   (p_valid),
  .q_valid   (q_valid)
);

// File: tb/test_raid6_pq_gen.sv
module test_raid6_pq_gen;

  localparam int LANES = 8;
  localparam int IDX_W = 4;
  localparam int BLK   = 4;
  localparam int W     = LANES * 8;
  localparam int NSRC  = 1 << IDX_W;
  localparam int WDOG  = 100000;

  // {err, mode[2], p_off, q_off, lo[4], hi[4], mask[16], seed[8]}
  localparam logic [36:0] VEC [8] = '{
    {1'b0, 2'd0, 1'b0, 1'b0, 4'd0, 4'd15, 16'h000F, 8'd1},
    {1'b1, 2'd0, 1'b1, 1'b1, 4'd0, 4'd15, 16'h0FF0, 8'd9},
    {1'b0, 2'd1, 1'b0, 1'b0, 4'd0, 4'd15, 16'h00F0, 8'd2},
    {1'b0, 2'd0, 1'b1, 1'b0, 4'd0, 4'd15, 16'hA5A5, 8'd3},
    {1'b0, 2'd0, 1'b0, 1'b1, 4'd0, 4'd15, 16'h8001, 8'd4},
    {1'b0, 2'd2, 1'b0, 1'b0, 4'd2, 4'd5,  16'hFFFF, 8'd5},
    {1'b0, 2'd0, 1'b0, 1'b0, 4'd0, 4'd15, 16'h8000, 8'd7},
    {1'b0, 2'd2, 1'b0, 1'b0, 4'd0, 4'd0,  16'h0003, 8'd6}
  };

  logic             clk;
  logic             rst_n;
  logic             job_start;
  logic [1:0]       job_mode;
  logic             job_p_off;
  logic             job_q_off;
  logic [IDX_W-1:0] job_lo;
  logic [IDX_W-1:0] job_hi;
  logic             job_err;
  logic             busy;
  logic             in_valid;
  logic             in_ready;
  logic [W-1:0]     in_data;
  logic [IDX_W-1:0] in_idx;
  logic             in_last;
  logic             p_valid;
  logic [W-1:0]     p_data;
  logic             q_valid;
  logic [W-1:0]     q_data;

  raid6_pq_gen #(.LANES(LANES), .IDX_W(IDX_W), .BLK_BEATS(BLK)) i_raid6_pq_gen (
    .clk(clk), .rst_n(rst_n), .job_start(job_start), .job_mode(job_mode),
    .job_p_off(job_p_off), .job_q_off(job_q_off), .job_lo(job_lo), .job_hi(job_hi),
    .job_err(job_err), .busy(busy), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_idx(in_idx), .in_last(in_last), .p_valid(p_valid),
    .p_data(p_data), .q_valid(q_valid), .q_data(q_data)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;
  logic [W-1:0] mp [BLK];
  logic [W-1:0] mq [BLK];

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WDOG) begin
      n_fail++;
      $display("FAIL watchdog: run hung, act=%0d cycles exp<=%0d", cyc, WDOG);
      report();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] m_dbl(input logic [7:0] a);
    return a[7] ? (({a[6:0], 1'b0}) ^ 8'h1D) : {a[6:0], 1'b0};
  endfunction

  function automatic logic [7:0] m_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] r = 8'h00;
    logic [7:0] x = a;
    for (int k = 0; k < 8; k++) begin
      if (b[k]) r ^= x;
      x = m_dbl(x);
    end
    return r;
  endfunction

  function automatic logic [W-1:0] m_scale(input logic [W-1:0] d, input int idx);
    logic [7:0] c = 8'h01;
    logic [W-1:0] r;
    for (int k = 0; k < idx; k++) c = m_dbl(c);
    for (int l = 0; l < LANES; l++) r[l*8 +: 8] = m_mul(d[l*8 +: 8], c);
    return r;
  endfunction

  function automatic logic [W-1:0] mkdata(input int seed, input int idx, input int b);
    logic [W-1:0] r;
    int v;
    for (int l = 0; l < LANES; l++) begin
      v = seed * 53 + idx * 29 + b * 17 + l * 97 + seed * idx * 7 + idx * l * 13;
      r[l*8 +: 8] = v[7:0] ^ v[15:8] ^ 8'h5A;
    end
    return r;
  endfunction

  task automatic send(input logic [W-1:0] d, input int idx, input bit last);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = d;
    in_idx   = IDX_W'(idx);
    in_last  = last;
    while (!in_ready) @(negedge clk);
  endtask

  task automatic run_job(input int mode, input bit poff, input bit qoff, input int lo,
                         input int hi, input logic [15:0] mask, input int seed,
                         input bit exp_err);
    bit desc;
    int fin;
    int i;
    logic [W-1:0] d;
    desc = seed[0];
    @(negedge clk);
    job_start = 1'b1;
    job_mode  = 2'(mode);
    job_p_off = poff;
    job_q_off = qoff;
    job_lo    = IDX_W'(lo);
    job_hi    = IDX_W'(hi);
    @(negedge clk);
    job_start = 1'b0;
    if (exp_err) begin
      // R5: refused request
      chk(job_err == 1'b1, "R5 err pulse", W'(job_err), W'(1));
      chk(busy == 1'b0 && in_ready == 1'b0, "R5 not started", W'({busy, in_ready}), W'(0));
      @(negedge clk);
      chk(job_err == 1'b0, "R5 err one cycle", W'(job_err), W'(0));
      return;
    end
    // R6: mode effects on the model
    if (mode != 1 && mode != 2) begin
      for (int b = 0; b < BLK; b++) begin
        mp[b] = '0;
        mq[b] = '0;
      end
    end
    if (mode == 2) begin
      for (int b = 0; b < BLK; b++) begin
        d = mkdata(seed + 100, 0, b);
        send(d, 0, 1'b0);
        mp[b] = d;
      end
      for (int b = 0; b < BLK; b++) begin
        d = mkdata(seed + 200, 0, b);
        send(d, 0, 1'b0);
        mq[b] = d;
      end
    end
    fin = -1;
    for (int k = 0; k < NSRC; k++) begin
      i = desc ? NSRC - 1 - k : k;
      if (mask[i]) fin = i;
    end
    for (int k = 0; k < NSRC; k++) begin
      i = desc ? NSRC - 1 - k : k;
      if (mask[i]) begin
        for (int b = 0; b < BLK; b++) begin
          d = mkdata(seed, i, b);
          send(d, i, (i == fin) && (b == BLK - 1));
          if (mode != 2 || (i >= lo && i <= hi)) begin
            if (!poff) mp[b] ^= d;
            if (!qoff) mq[b] ^= m_scale(d, i);
          end
        end
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_last  = 1'b0;
    // R8 / R10: drain beats in order
    for (int b = 0; b < BLK; b++) begin
      chk(p_valid == !poff, "R4 p_valid", W'(p_valid), W'(!poff));
      chk(q_valid == !qoff, "R4 q_valid", W'(q_valid), W'(!qoff));
      chk(in_ready == 1'b0, "R8 in_ready in drain", W'(in_ready), W'(0));
      if (!poff) chk(p_data == mp[b], "R1/R3/R7/R10 P beat", p_data, mp[b]);
      if (!qoff) chk(q_data == mq[b], "R2/R3/R7/R10 Q beat", q_data, mq[b]);
      @(negedge clk);
    end
    chk(!p_valid && !q_valid && !busy, "R8 drain length", W'({p_valid, q_valid, busy}), W'(0));
  endtask

  initial begin
    rst_n     = 1'b0;
    job_start = 1'b0;
    job_mode  = '0;
    job_p_off = 1'b0;
    job_q_off = 1'b0;
    job_lo    = '0;
    job_hi    = '0;
    in_valid  = 1'b0;
    in_data   = '0;
    in_idx    = '0;
    in_last   = 1'b0;
    for (int b = 0; b < BLK; b++) begin
      mp[b] = '0;
      mq[b] = '0;
    end
    repeat (3) @(negedge clk);
    // R9: outputs during reset
    chk({busy, in_ready, p_valid, q_valid, job_err} == 5'b0, "R9 in reset",
        W'({busy, in_ready, p_valid, q_valid, job_err}), W'(0));
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk({busy, in_ready, p_valid, q_valid, job_err} == 5'b0, "R9 after reset",
        W'({busy, in_ready, p_valid, q_valid, job_err}), W'(0));

    for (int n = 0; n < 8; n++) begin
      logic [36:0] e;
      e = VEC[n];
      run_job(int'(e[35:34]), e[33], e[32], int'(e[31:28]), int'(e[27:24]),
              e[23:8], int'(e[7:0]), e[36]);
    end

    // random stripes with random absent sources, all modes
    for (int n = 0; n < 24; n++) begin
      int mode;
      int sel;
      int lo;
      int hi;
      int t;
      logic [15:0] mask;
      mode = int'($urandom % 3);
      sel  = int'($urandom % 4);
      mask = 16'($urandom);
      if (mask == 16'h0) mask = 16'h0100;
      lo = int'($urandom % NSRC);
      hi = int'($urandom % NSRC);
      if (lo > hi) begin
        t  = lo;
        lo = hi;
        hi = t;
      end
      run_job(mode, sel == 1, sel == 2, lo, hi, mask, 20 + n, 1'b0);
    end

    report();
    $finish;
  end

endmodule